// File: doc/BRIEF.md
# CSMA/CD Retry and Backoff Controller

This block decides when a half-duplex MAC on a shared medium may start sending a frame. Once a send request arrives, it watches the carrier. It waits until the line has been quiet for a full interframe gap and then tells the transmitter to go. The controller is persistent: it keeps watching a busy line and goes as soon as the gap has passed.

If the transmitter reports a collision while sending, the controller cancels the attempt. It then waits a random whole number of slot times. The range of that number doubles with each collision on the same frame, up to a cap. After the wait it defers for the gap again and retries. When the attempt limit is reached, it declares the frame lost.

All waits are counted in bit-time ticks from an external time base. A slot is 512 ticks and the gap is 96 ticks; both are parameters. Frame contents, the jam sequence and the checksum belong to other blocks.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_start`, `tx_abort` and `tx_fail` are low and the controller is idle.
- R2: A request accepted with the line quiet gives a one-cycle `tx_start` exactly GAP_TICKS ticked cycles after the cycle the request was sampled.
- R3: Carrier high at any tick during deferral restarts the gap count. `tx_start` follows GAP_TICKS ticks after the carrier last fell, and never in a cycle after carrier was high.
- R4: A collision sampled while a frame is being sent gives a one-cycle `tx_abort`, never in the same cycle as `tx_start`.
- R5: After the c-th collision of a frame, the next `tx_start` comes k*SLOT_TICKS + 1 + GAP_TICKS cycles after `tx_abort` (ticks every cycle, line quiet). Here k is drawn from 0 to 2^min(c,EXP_CAP) − 1 using the low bits of a free-running LFSR.
- R6: The ATTEMPT_LIMIT-th collision of a frame pulses `tx_fail` together with `tx_abort`. No further `tx_start` follows without a new request, and the collision count restarts from zero.
- R7: `tx_done` while sending ends the frame and clears the collision count, so the next frame's first backoff is 0 or 1 slot.
- R8: `collision` outside an active transmission is ignored: no `tx_abort`, and the start timing is unchanged.
- R9: Gap and slot timers advance only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle bit-time strobe |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision reported by the transmitter |
| tx_request | input | 1 | Frame waiting; sampled while idle |
| tx_done | input | 1 | Transmitter finished the frame cleanly |
| tx_start | output | 1 | Pulse: begin sending now |
| tx_abort | output | 1 | Pulse: stop sending, collision seen |
| tx_fail | output | 1 | Pulse: frame given up |

## Verification
The bench measures the distance from each abort to the next start. It then requires that distance to be a whole number of slots plus the fixed overhead, with the slot count inside the doubling range. A design that miscounted the range, or never capped it, would produce a count out of bounds. A carrier blip in mid-gap and a stalled tick catch a gap timer that fails to restart or that runs on the clock instead of the tick. Stray collisions during deferral and backoff, the full attempt-limit run, and a clean completion after several collisions expose a controller that counts collisions it should ignore, retries past the limit, or carries its collision count into the next frame.

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl #(
  parameter int SLOT_TICKS    = 512,
  parameter int GAP_TICKS     = 96,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int EXP_CAP       = 10,
  parameter int LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic carrier_sense,
  input  logic collision,
  input  logic tx_request,
  input  logic tx_done,
  output logic tx_start,
  output logic tx_abort,
  output logic tx_fail
);

  localparam int SLOT_W = $clog2(SLOT_TICKS);
  localparam int GAP_W  = $clog2(GAP_TICKS + 1);
  localparam int ATT_W  = $clog2(ATTEMPT_LIMIT + 1);
  localparam int K_W    = EXP_CAP;

  typedef enum logic [1:0] {S_IDLE, S_DEFER, S_XMIT, S_BACKOFF} state_t;

  state_t            state;
  logic [GAP_W-1:0]  gap_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic [K_W-1:0]    slots_left;
  logic [ATT_W-1:0]  coll_cnt;
  logic [LFSR_W-1:0] lfsr;
  logic [K_W-1:0]    k_mask;

  wire [ATT_W-1:0] coll_next = coll_cnt + 1'b1;
  wire gap_done  = tick && !carrier_sense && (gap_cnt == GAP_W'(GAP_TICKS - 1));
  wire slot_end  = slot_cnt == SLOT_W'(SLOT_TICKS - 1);
  wire hit_limit = coll_next == ATT_W'(ATTEMPT_LIMIT);

  always_comb begin
    int e;
    e = int'(coll_next);
    if (e > EXP_CAP) e = EXP_CAP;
    for (int i = 0; i < K_W; i++) k_mask[i] = (i < e);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      gap_cnt    <= '0;
      slot_cnt   <= '0;
      slots_left <= '0;
      coll_cnt   <= '0;
      tx_start   <= 1'b0;
      tx_abort   <= 1'b0;
      tx_fail    <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      tx_abort <= 1'b0;
      tx_fail  <= 1'b0;
      case (state)
        S_IDLE:
          if (tx_request) begin
            state   <= S_DEFER;
            gap_cnt <= '0;
          end
        S_DEFER:
          if (carrier_sense)  gap_cnt <= '0;
          else if (gap_done) begin
            tx_start <= 1'b1;
            state    <= S_XMIT;
          end else if (tick)  gap_cnt <= gap_cnt + 1'b1;
        S_XMIT:
          if (collision) begin
            tx_abort <= 1'b1;
            if (hit_limit) begin
              tx_fail  <= 1'b1;
              coll_cnt <= '0;
              state    <= S_IDLE;
            end else begin
              coll_cnt   <= coll_next;
              slots_left <= lfsr[K_W-1:0] & k_mask;
              slot_cnt   <= '0;
              state      <= S_BACKOFF;
            end
          end else if (tx_done) begin
            coll_cnt <= '0;
            state    <= S_IDLE;
          end
        S_BACKOFF:
          if (slots_left == '0) begin
            state   <= S_DEFER;
            gap_cnt <= '0;
          end else if (tick) begin
            if (slot_end) begin
              slot_cnt   <= '0;
              slots_left <= slots_left - 1'b1;
            end else slot_cnt <= slot_cnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/csma_backoff_ctrl_chk.sv
module csma_backoff_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic carrier_sense,
  input logic collision,
  input logic tx_start,
  input logic tx_abort,
  input logic tx_fail
);

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !(tx_start || tx_abort || tx_fail));

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  p_start_line_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !$past(carrier_sense));

  p_abort_from_coll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> ($past(collision) && !tx_start));

  p_wait_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_start);

  p_fail_is_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |-> tx_abort);

  p_start_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(tick));

endmodule

bind csma_backoff_ctrl csma_backoff_ctrl_chk u_chk (.*);

// File: tb/test_csma_backoff_ctrl.sv
module test_csma_backoff_ctrl;
  localparam int SLOT  = 8;
  localparam int GAP   = 4;
  localparam int LIMIT = 16;
  localparam int CAP   = 10;
  localparam int LONG  = ((1 << CAP) * SLOT) + GAP + 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic carrier_sense = 1'b0, collision = 1'b0, tx_request = 1'b0, tx_done = 1'b0;
  logic tx_start, tx_abort, tx_fail;
  int n_vec = 0, n_bad = 0;

  csma_backoff_ctrl #(.SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .ATTEMPT_LIMIT(LIMIT), .EXP_CAP(CAP))
    i_csma_backoff_ctrl (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic request();
    tx_request = 1'b1; step(); tx_request = 1'b0;
  endtask

  task automatic finish_frame();
    tx_done = 1'b1; step(); tx_done = 1'b0;
  endtask

  task automatic wait_start(input int lim, output int n, output int aborts);
    bit seen = 1'b0;
    n = 0; aborts = 0;
    while (!seen && n < lim) begin
      step(); n++;
      if (tx_abort) aborts++;
      if (tx_start) seen = 1'b1;
    end
  endtask

  function automatic int range_max(input int c);
    return (1 << ((c > CAP) ? CAP : c)) - 1;
  endfunction

  // One collision on the frame being sent, then measure the retry distance.
  task automatic collide_and_retry(input int c, input string req, output int k);
    int n, ab, rem;
    collision = 1'b1; step(); collision = 1'b0;
    check(tx_abort && !tx_start && !tx_fail, "R4", {tx_abort, tx_start, tx_fail}, 3'b100);
    wait_start(LONG, n, ab);
    rem = n - 1 - GAP;
    k = rem / SLOT;
    check(rem >= 0 && rem % SLOT == 0 && k <= range_max(c), req, n, range_max(c));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step();
    check({tx_start, tx_abort, tx_fail} == 3'b000, "R1", {tx_start, tx_abort, tx_fail}, 0);
    rst_n = 1'b1; step();
  endtask

  task automatic t_clean_start();
    int n, ab;
    request();
    wait_start(50, n, ab);
    check(n == GAP && tx_start, "R2", n, GAP);
    step();
    check(!tx_start, "R2", tx_start, 0);
    finish_frame();
  endtask

  task automatic t_carrier_defer();
    int n, ab;
    carrier_sense = 1'b1;
    request();
    wait_start(20, n, ab);
    check(!tx_start && n == 20, "R3", n, 20);
    carrier_sense = 1'b0;
    wait_start(50, n, ab);
    check(n == GAP && tx_start, "R3", n, GAP);
    finish_frame();
    request();
    step(); step();
    carrier_sense = 1'b1; step(); carrier_sense = 1'b0;
    wait_start(50, n, ab);
    check(n == GAP && tx_start, "R3", n, GAP);
    finish_frame();
  endtask

  task automatic t_backoff();
    int n, ab, k;
    request();
    wait_start(50, n, ab);
    for (int c = 1; c <= 5; c++) collide_and_retry(c, "R5", k);
    finish_frame();
  endtask

  task automatic t_ignore_collision();
    int n, ab, k;
    request();
    collision = 1'b1; step(); collision = 1'b0;
    check(!tx_abort, "R8", tx_abort, 0);
    wait_start(50, n, ab);
    check(n == GAP - 1 && ab == 0, "R8", n, GAP - 1);
    collision = 1'b1; step(); collision = 1'b0;
    check(tx_abort, "R4", tx_abort, 1);
    collision = 1'b1; step(); collision = 1'b0;
    check(!tx_abort, "R8", tx_abort, 0);
    wait_start(LONG, n, ab);
    k = (n - GAP) / SLOT;
    check(ab == 0 && tx_start && (n - GAP) % SLOT == 0 && k <= 1, "R8", n, GAP + 1);
    finish_frame();
  endtask

  task automatic t_tick_gate();
    int n, ab;
    tick = 1'b0;
    request();
    wait_start(3 * GAP, n, ab);
    check(!tx_start, "R9", tx_start, 0);
    tick = 1'b1;
    wait_start(50, n, ab);
    check(n == GAP && tx_start, "R9", n, GAP);
    finish_frame();
  endtask

  task automatic t_limit();
    int n, ab, k;
    request();
    wait_start(50, n, ab);
    for (int c = 1; c < LIMIT; c++) collide_and_retry(c, "R5", k);
    collision = 1'b1; step(); collision = 1'b0;
    check(tx_abort && tx_fail, "R6", {tx_abort, tx_fail}, 2'b11);
    wait_start(100, n, ab);
    check(!tx_start, "R6", tx_start, 0);
    request();
    wait_start(50, n, ab);
    collide_and_retry(1, "R6", k);
    finish_frame();
  endtask

  task automatic t_done_clears();
    int n, ab, k;
    for (int rep = 0; rep < 2; rep++) begin
      request();
      wait_start(50, n, ab);
      for (int c = 1; c <= 4; c++) collide_and_retry(c, "R5", k);
      finish_frame();
      request();
      wait_start(50, n, ab);
      collide_and_retry(1, "R7", k);
      finish_frame();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clean_start();
    t_carrier_defer();
    t_backoff();
    t_ignore_collision();
    t_tick_gate();
    t_limit();
    t_done_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule